// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins. The number of pins is a parameter and may be any count up to the bus width. Software drives an output value and an output enable for each pin. It can read back the synchronised level of each pin. Each pin carries its own event detector. The detector is set per pin to edge or level triggering, and one polarity bit gives the direction. Every detected event sets a sticky pending bit, whether or not the pin's interrupt is enabled. Software removes pending bits by writing ones to the clear register. The block has one interrupt line, which is the OR over all pins of the pending bits that are also enabled.

Level events are sticky too. A level pending bit stays set after the pin goes inactive, until it is cleared. The hardware has no mode that fires on both edges. Software gets that behaviour by writing the polarity bit to the opposite of the level it last saw after each event. Changing the polarity of an edge-mode pin does not create an event, so this rewrite is safe.

The register port is a plain synchronous bus. A write takes effect at the clock edge where it is presented. Read data is registered and appears one cycle after the read request. The block has no state machine: every path is a fixed pipeline. A pin change passes two synchroniser flops, then the detector compares the synchronised level with its value on the previous clock, and the pending bit is set one edge after that.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the output value, output enable, trigger type, polarity and interrupt enable registers all read zero, and pin_out, pin_oe and irq are 0.
- R2: Writes to the output value and output enable registers drive pin_out and pin_oe and read back. Bit positions at or above NPINS read as zero whatever was written.
- R3: The input level register returns the pin_in level once that level has been stable for three clock cycles (two synchroniser flops and one read register).
- R4: With the trigger bit at 1 (edge), polarity 1 latches a pending bit on a 0-to-1 transition and polarity 0 latches one on a 1-to-0 transition. A transition in the other direction latches nothing.
- R5: With the trigger bit at 0 (level), polarity 1 latches a pending bit while the pin is high and polarity 0 latches one while it is low. The bit stays set after the pin goes inactive, until it is cleared.
- R6: Writing the clear register removes the pending bits written as 1. Bits written as 0 are left unchanged.
- R7: Pending bits latch events whether or not the pin's interrupt enable bit is set.
- R8: irq is 1 exactly when some pin has both its pending bit and its interrupt enable bit set.
- R9: When a new event and a clear of the same bit fall in the same cycle, the bit stays set.
- R10: Rewriting the polarity of an edge-mode pin whose input is steady creates no event. Flipping polarity after each event therefore gives detection on both edges.
- R11: bus_addr selects a word: 0 output value, 1 output enable, 2 input level (read-only), 3 trigger type, 4 polarity, 5 interrupt enable, 6 clear (write-only, reads 0), 7 pending status (read-only). bus_rdata is updated in the cycle after bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output values |
| pin_oe | output | NPINS | Output enables |
| irq | output | 1 | Aggregated interrupt |

## Verification
The hardest case to reach from the ports is an event and a clear of the same bit landing on the same clock edge. This case needs the bench to count the synchroniser latency exactly. The bench raises a pin half a cycle before an edge, waits two edges and presents the clear on the third, where the detector fires. It then reads status to confirm the bit survived. Random trials apply random trigger, polarity and enable patterns and step every pin from one random level to another. The bench computes the expected status and interrupt from the old level, the new level and the configuration.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 3;

    // Word index of each register on the bus.
    typedef enum logic [ADDR_W-1:0] {
        RI_OUT_VAL = 3'd0,
        RI_OUT_EN  = 3'd1,
        RI_PIN_LVL = 3'd2,
        RI_TRIG    = 3'd3,
        RI_POL     = 3'd4,
        RI_IRQ_EN  = 3'd5,
        RI_CLEAR   = 3'd6,
        RI_STATUS  = 3'd7
    } reg_idx_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 27,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_event.sv
module gpio_event #(
    parameter int W = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] trig_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] event_v;
    logic [W-1:0] status_q;

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise_v, fall_v, edge_hit, level_hit;
        always_comb begin
            rise_v    = lvl_i[i] & ~prev_q[i];
            fall_v    = ~lvl_i[i] & prev_q[i];
            edge_hit  = pol_i[i] ? rise_v : fall_v;
            level_hit = (lvl_i[i] == pol_i[i]);
            event_v[i] = trig_i[i] ? edge_hit : level_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            status_q <= '0;
        end else begin
            prev_q   <= lvl_i;
            // a new event has priority over a same-cycle clear
            status_q <= (status_q & ~clr_i) | event_v;
        end
    end

    assign status_o = status_q;

    // R9
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (event_v != '0) |=> ((status_q & $past(event_v)) == $past(event_v)));

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~event_v) != '0) |=> ((status_q & $past(clr_i & ~event_v)) == '0));

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~clr_i) != '0) |=> ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i)));

    // R10
    steady_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((event_v & trig_i & ~(lvl_i ^ prev_q)) == '0));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int W  = 27,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    input  logic [W-1:0]      lvl_i,
    input  logic [W-1:0]      status_i,
    output logic [W-1:0]      out_val_o,
    output logic [W-1:0]      out_en_o,
    output logic [W-1:0]      trig_o,
    output logic [W-1:0]      pol_o,
    output logic [W-1:0]      irq_en_o,
    output logic [W-1:0]      clr_o
);
    reg_idx_e     idx;
    logic [W-1:0] wbits;
    logic [W-1:0] out_val_q, out_en_q, trig_q, pol_q, irq_en_q;
    logic [W-1:0] rd_sel;
    logic [DW-1:0] rd_next, rdata_q;
    logic          unused_wdata;

    assign idx          = reg_idx_e'(addr_i);
    assign wbits        = wdata_i[W-1:0];
    assign unused_wdata = ^wdata_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_val_q <= '0;
            out_en_q  <= '0;
            trig_q    <= '0;
            pol_q     <= '0;
            irq_en_q  <= '0;
        end else if (wr_i) begin
            unique case (idx)
                RI_OUT_VAL: out_val_q <= wbits;
                RI_OUT_EN:  out_en_q  <= wbits;
                RI_TRIG:    trig_q    <= wbits;
                RI_POL:     pol_q     <= wbits;
                RI_IRQ_EN:  irq_en_q  <= wbits;
                RI_PIN_LVL, RI_CLEAR, RI_STATUS: ;
            endcase
        end
    end

    assign clr_o = (wr_i && idx == RI_CLEAR) ? wbits : '0;

    always_comb begin
        unique case (idx)
            RI_OUT_VAL: rd_sel = out_val_q;
            RI_OUT_EN:  rd_sel = out_en_q;
            RI_PIN_LVL: rd_sel = lvl_i;
            RI_TRIG:    rd_sel = trig_q;
            RI_POL:     rd_sel = pol_q;
            RI_IRQ_EN:  rd_sel = irq_en_q;
            RI_CLEAR:   rd_sel = '0;
            RI_STATUS:  rd_sel = status_i;
        endcase
        rd_next         = '0;
        rd_next[W-1:0]  = rd_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_next;
    end

    assign rdata_o   = rdata_q;
    assign out_val_o = out_val_q;
    assign out_en_o  = out_en_q;
    assign trig_o    = trig_q;
    assign pol_o     = pol_q;
    assign irq_en_o  = irq_en_q;

    // R11
    clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == RI_CLEAR) |=> (rdata_o == '0));

    // R2
    if (W < DW) begin : g_hi_chk
        upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rdata_o[DW-1:W] == '0));
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 27,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam int SYNC_STAGES = 2;

    logic [NPINS-1:0] lvl_s, trig_s, pol_s, irq_en_s, clr_s, status_s;

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_in),
        .sync_o (lvl_s)
    );

    gpio_event #(.W(NPINS)) u_event (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (lvl_s),
        .trig_i  (trig_s),
        .pol_i   (pol_s),
        .clr_i   (clr_s),
        .status_o(status_s)
    );

    gpio_regs #(.W(NPINS), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .rd_i     (bus_rd),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .rdata_o  (bus_rdata),
        .lvl_i    (lvl_s),
        .status_i (status_s),
        .out_val_o(pin_out),
        .out_en_o (pin_oe),
        .trig_o   (trig_s),
        .pol_o    (pol_s),
        .irq_en_o (irq_en_s),
        .clr_o    (clr_s)
    );

    assign irq = |(status_s & irq_en_s);

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_s == '0) |-> !irq);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_en_s == '0 && pin_out == '0 && pin_oe == '0));
endmodule

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
    localparam int NP = 27;
    localparam int DW = 32;
    localparam logic [31:0] MASK = (32'h1 << NP) - 32'h1;

    logic clk = 0, rst_n = 0;
    logic bus_wr = 0, bus_rd = 0;
    logic [2:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0, bus_rdata;
    logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
    logic irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_irq_bank #(.NPINS(NP), .DW(DW)) u_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [31:0] lvl_hits(logic [31:0] t, logic [31:0] p, logic [31:0] v);
        return ~t & ~(v ^ p) & MASK;
    endfunction

    function automatic logic [31:0] edge_hits(logic [31:0] t, logic [31:0] p,
                                              logic [31:0] a, logic [31:0] b);
        return t & ((p & ~a & b) | (~p & a & ~b)) & MASK;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1; bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(posedge clk); #1; bus_rd = 0; d = bus_rdata;
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk); pin_in = v[NP-1:0];
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d, t, p, en, a, b, exp;
        void'($urandom(32'h5EED1));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        for (int r = 0; r < 6; r++) begin
            if (r == 2) continue;
            rd(r[2:0], d);
            check("R1 reset register", d, 32'h0);
        end
        check("R1 pin_out/pin_oe/irq", {pin_out != 0, pin_oe != 0, irq}, 32'h0);

        // R2 output regs and unused upper bits
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d);
        check("R2 out value readback", d, MASK);
        check("R2 pin_out", {5'd0, pin_out}, MASK);
        wr(3'd1, 32'hA5A5_A5A5);
        rd(3'd1, d);
        check("R2 out enable readback", d, 32'hA5A5_A5A5 & MASK);
        check("R2 pin_oe", {5'd0, pin_oe}, 32'hA5A5_A5A5 & MASK);

        // R11 clear reads zero, status read-only
        rd(3'd6, d);
        check("R11 clear reads 0", d, 32'h0);

        // base config: all edge, rising
        wr(3'd3, MASK); wr(3'd4, MASK);
        settle(); wr(3'd6, MASK);
        rd(3'd7, d);
        check("R6 clear all", d, 32'h0);

        // R3 input level
        set_pins(32'h0123_4567 & MASK); settle();
        rd(3'd2, d);
        check("R3 input level", d, 32'h0123_4567 & MASK);
        // R4 rising edges latched
        rd(3'd7, d);
        check("R4 rising edges", d, 32'h0123_4567 & MASK);
        // R6 clear with zero bits untouched
        wr(3'd6, 32'h0000_0007);
        rd(3'd7, d);
        check("R6 partial clear", d, 32'h0123_4560 & MASK);
        wr(3'd6, MASK);
        // R4 falling direction ignored under rising polarity
        set_pins(32'h0); settle();
        rd(3'd7, d);
        check("R4 falling ignored", d, 32'h0);

        // R10 polarity rewrite with steady input: no event
        wr(3'd4, 32'h0);
        settle();
        rd(3'd7, d);
        check("R10 pol flip no event", d, 32'h0);
        set_pins(32'h20); settle();
        rd(3'd7, d);
        check("R4 rise ignored at falling pol", d, 32'h0);
        set_pins(32'h0); settle();
        rd(3'd7, d);
        check("R4 falling edge latched", d, 32'h20);
        wr(3'd6, MASK);
        wr(3'd4, MASK);

        // R7 / R8 interrupt aggregation
        set_pins(32'h100); settle();
        check("R7 status without enable irq low", {31'd0, irq}, 32'h0);
        rd(3'd7, d);
        check("R7 latched while disabled", d, 32'h100);
        wr(3'd5, 32'h200); #1;
        check("R8 other enable irq low", {31'd0, irq}, 32'h0);
        wr(3'd5, 32'h300); #1;
        check("R8 irq high", {31'd0, irq}, 32'h1);
        wr(3'd6, 32'h100); #1;
        check("R8 irq drops after clear", {31'd0, irq}, 32'h0);
        wr(3'd5, 32'h0);

        // R9 event and clear on the same edge
        @(negedge clk); pin_in[9] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1; bus_addr = 3'd6; bus_wdata = 32'h200;
        @(posedge clk); #1; bus_wr = 0;
        rd(3'd7, d);
        check("R9 event beats clear", d, 32'h200);
        wr(3'd6, 32'h200);
        rd(3'd7, d);
        check("R6 later clear works", d, 32'h0);
        set_pins(32'h0); settle(); wr(3'd6, MASK);

        // R5 level detection, sticky
        wr(3'd3, MASK & ~32'h8);
        wr(3'd4, MASK);
        wr(3'd6, MASK);
        set_pins(32'h8); settle();
        rd(3'd7, d);
        check("R5 active-high latched", d, 32'h8);
        set_pins(32'h0); settle();
        rd(3'd7, d);
        check("R5 pending after inactive", d, 32'h8);
        wr(3'd6, 32'h8);
        rd(3'd7, d);
        check("R5 cleared", d, 32'h0);
        wr(3'd4, MASK & ~32'h8); settle();
        rd(3'd7, d);
        check("R5 active-low latched", d, 32'h8);

        // random trials
        for (int k = 0; k < 60; k++) begin
            t  = $urandom() & MASK;
            p  = $urandom() & MASK;
            en = $urandom() & MASK;
            a  = $urandom() & MASK;
            b  = $urandom() & MASK;
            set_pins(a);
            wr(3'd3, t); wr(3'd4, p); wr(3'd5, en);
            settle();
            wr(3'd6, MASK);
            rd(3'd7, d);
            check("R5 random level after clear", d, lvl_hits(t, p, a));
            set_pins(b); settle();
            exp = lvl_hits(t, p, a) | lvl_hits(t, p, b) | edge_hits(t, p, a, b);
            rd(3'd7, d);
            check("R4 random status", d, exp);
            check("R8 random irq", {31'd0, irq}, {31'd0, |(exp & en)});
            rd(3'd2, d);
            check("R3 random input level", d, b);
        end
        finish_run();
    end
endmodule